// File: doc/BRIEF.md
# Hotplug Event and Slot Mask Register Block

This block collects slot hotplug notifications and presents them to software as general-purpose events. A 16-bit event status register and a 16-bit event enable register are reached one byte at a time over a small byte port. Status bits are cleared by writing ones. Enable bytes are replaced outright. Two slot masks, one for inserted slots and one for removed slots, are reached over a 32-bit word port. That port also holds an eject register that converts a written bit vector into a single slot index.

A hotplug request is one cycle on `hp_valid`, carrying a slot number and an insert/remove flag. Each request wipes both slot masks and then records its own slot in the mask that matches its direction. It always raises event status bit 1. If enable bit 1 was already set, it also produces a one-cycle interrupt pulse. A write to the eject register produces a one-cycle strobe carrying the index of the lowest set bit of the written word. Software can act on that strobe to take the device out.

Top module: `gpe_hotplug_regs`

## Requirements
- R1: On the byte port, address 0 reads the status low byte, 1 the status high byte, 2 the enable low byte and 3 the enable high byte. Reads are combinational.
- R2: A byte write to address 0 or 1 clears exactly the status bits written as 1 in that byte lane. The other lane keeps its value.
- R3: A byte write to address 2 or 3 replaces that enable byte. The other enable byte keeps its value.
- R4: After a hotplug request, both slot masks hold zero except bit `hp_slot`. That bit is set in the inserted mask when `hp_insert`=1 and in the removed mask when `hp_insert`=0. The masks show this from the cycle after the request.
- R5: Every hotplug request sets status bit 1 from the next cycle. This holds even when a byte write clears that bit in the same cycle.
- R6: `sci_irq` is high for exactly the one cycle after a hotplug request if enable bit 1 was set before the request. Otherwise it stays low.
- R7: On the word port, word index 0 is the inserted mask and index 1 is the removed mask. Both can be read and written. Bits at and above NUM_SLOTS read as zero. A hotplug request overrides a same-cycle mask write.
- R8: A word write to index 2 (eject) with a nonzero value makes `eject_valid` high for one cycle, in the next cycle. `eject_slot` then equals the index of the lowest set bit of the value. Index 2 and index 3 read as zero.
- R9: A word write of zero to the eject register produces no strobe.
- R10: While `rst_n` is low at a clock edge, the status, the enable and both masks become zero, and `sci_irq` and `eject_valid` become low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bb_we | input | 1 | Byte port write enable |
| bb_addr | input | 2 | Byte port address |
| bb_wdata | input | 8 | Byte port write data |
| bb_rdata | output | 8 | Byte port read data |
| wd_we | input | 1 | Word port write enable |
| wd_word | input | 2 | Word index (0 inserted, 1 removed, 2 eject) |
| wd_wdata | input | 32 | Word port write data |
| wd_rdata | output | 32 | Word port read data |
| hp_valid | input | 1 | Hotplug request strobe |
| hp_slot | input | SLOT_W | Slot of the request |
| hp_insert | input | 1 | 1 for insertion, 0 for removal |
| sci_irq | output | 1 | One-cycle event interrupt pulse |
| eject_valid | output | 1 | One-cycle eject strobe |
| eject_slot | output | 5 | Slot chosen by the eject write |

## Verification
The bench builds the block with NUM_SLOTS=8, so a 3-bit slot field addresses every slot. Every slot can then be hotplugged in both directions, and the bench can confirm that mask bits above the slot count read zero. At this size the bench sweeps all 256 values through each status lane and each enable lane. It walks a single set bit, and a single bit with a high bit added, through all 32 eject positions. It also drives the same-cycle collisions of a hotplug request with a status clear and with a mask write, and applies a reset in the middle of the run.

// File: rtl/gpe_hp_pkg.sv
// Shared constants for the hotplug event block.
// Assumes a 16-bit status/enable pair split into two byte lanes.
package gpe_hp_pkg;
    localparam int GPE_W    = 16;
    localparam int LANE_W   = 8;
    localparam int N_LANES  = GPE_W / LANE_W;
    localparam int WORD_W   = 32;
    localparam int EJ_IDX_W = $clog2(WORD_W);

    typedef enum logic [1:0] {
        W_INSERTED = 2'd0,
        W_REMOVED  = 2'd1,
        W_EJECT    = 2'd2,
        W_SPARE    = 2'd3
    } word_sel_e;
endpackage

// File: rtl/gpe_byte_regs.sv
// Event status (write-1-to-clear) and enable (replace) registers, byte lanes.
// Assumes addresses 0..N_LANES-1 map status lanes, the next N_LANES map enable lanes.
// A hotplug set of status bit HP_BIT wins over a same-cycle clear.
module gpe_byte_regs
    import gpe_hp_pkg::*;
#(
    parameter int HP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [LANE_W-1:0] wdata,
    input  logic              hp_set,
    output logic [GPE_W-1:0]  sts,
    output logic [GPE_W-1:0]  en,
    output logic [LANE_W-1:0] rdata
);
    localparam int HP_LANE = HP_BIT / LANE_W;
    localparam int HP_POS  = HP_BIT % LANE_W;

    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] sts_nxt;

        // Next status lane: clear written ones, then apply the hotplug set
        always_comb begin
            sts_nxt = sts[ln*LANE_W +: LANE_W];
            if (we && addr == 2'(ln))
                sts_nxt = sts_nxt & ~wdata;
            if (hp_set && ln == HP_LANE)
                sts_nxt[HP_POS] = 1'b1;
        end

        // Status lane register
        always_ff @(posedge clk) begin
            if (!rst_n) sts[ln*LANE_W +: LANE_W] <= '0;
            else        sts[ln*LANE_W +: LANE_W] <= sts_nxt;
        end

        // Enable lane register: full replace on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                en[ln*LANE_W +: LANE_W] <= '0;
            else if (we && addr == 2'(N_LANES + ln))
                en[ln*LANE_W +: LANE_W] <= wdata;
        end
    end

    // Byte read multiplexer
    always_comb begin
        case (addr)
            2'd0:    rdata = sts[LANE_W-1:0];
            2'd1:    rdata = sts[GPE_W-1:LANE_W];
            2'd2:    rdata = en[LANE_W-1:0];
            default: rdata = en[GPE_W-1:LANE_W];
        endcase
    end
endmodule

// File: rtl/slot_mask_regs.sv
// Inserted/removed slot masks. A hotplug request wipes both masks and
// records one slot; it overrides a software write in the same cycle.
// Assumes NUM_SLOTS <= WORD_W and NUM_SLOTS a power of two.
module slot_mask_regs
    import gpe_hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_ins,
    input  logic                 we_rem,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 hp_valid,
    input  logic [SLOT_W-1:0]    hp_slot,
    input  logic                 hp_insert,
    output logic [NUM_SLOTS-1:0] ins_mask,
    output logic [NUM_SLOTS-1:0] rem_mask
);
    logic [NUM_SLOTS-1:0] slot_bit;

    // One-hot decode of the requested slot
    always_comb slot_bit = NUM_SLOTS'(1) << hp_slot;

    // Inserted mask update
    always_ff @(posedge clk) begin
        if (!rst_n)        ins_mask <= '0;
        else if (hp_valid) ins_mask <= hp_insert ? slot_bit : '0;
        else if (we_ins)   ins_mask <= wdata[NUM_SLOTS-1:0];
    end

    // Removed mask update
    always_ff @(posedge clk) begin
        if (!rst_n)        rem_mask <= '0;
        else if (hp_valid) rem_mask <= hp_insert ? '0 : slot_bit;
        else if (we_rem)   rem_mask <= wdata[NUM_SLOTS-1:0];
    end
endmodule

// File: rtl/eject_encoder.sv
// Turns an eject write into a one-cycle strobe carrying the index of the
// lowest set bit. A zero word gives no strobe.
module eject_encoder
    import gpe_hp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [WORD_W-1:0]   wdata,
    output logic                eject_valid,
    output logic [EJ_IDX_W-1:0] eject_slot
);
    logic [EJ_IDX_W-1:0] low_idx;

    // Lowest set bit search: scanning downward leaves the lowest hit
    always_comb begin
        low_idx = '0;
        for (int i = WORD_W - 1; i >= 0; i--)
            if (wdata[i]) low_idx = EJ_IDX_W'(i);
    end

    // Strobe and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eject_valid <= 1'b0;
            eject_slot  <= '0;
        end else begin
            eject_valid <= fire && (wdata != '0);
            if (fire) eject_slot <= low_idx;
        end
    end
endmodule

// File: rtl/gpe_hotplug_regs.sv
// Top of the hotplug event block: byte-lane event registers, word-port slot
// masks and eject register, and the registered event interrupt pulse.
// Assumes at most one hotplug request per cycle.
module gpe_hotplug_regs
    import gpe_hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int HP_BIT    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bb_we,
    input  logic [1:0]          bb_addr,
    input  logic [7:0]          bb_wdata,
    output logic [7:0]          bb_rdata,
    input  logic                wd_we,
    input  logic [1:0]          wd_word,
    input  logic [31:0]         wd_wdata,
    output logic [31:0]         wd_rdata,
    input  logic                hp_valid,
    input  logic [SLOT_W-1:0]   hp_slot,
    input  logic                hp_insert,
    output logic                sci_irq,
    output logic                eject_valid,
    output logic [4:0]          eject_slot
);
    logic [GPE_W-1:0]     gpe_sts;
    logic [GPE_W-1:0]     gpe_en;
    logic [NUM_SLOTS-1:0] ins_mask;
    logic [NUM_SLOTS-1:0] rem_mask;
    logic                 we_ins, we_rem, we_ej;

    // Word port write decode
    always_comb begin
        we_ins = wd_we && (wd_word == W_INSERTED);
        we_rem = wd_we && (wd_word == W_REMOVED);
        we_ej  = wd_we && (wd_word == W_EJECT);
    end

    gpe_byte_regs #(.HP_BIT(HP_BIT)) u_bytes (
        .clk(clk), .rst_n(rst_n), .we(bb_we), .addr(bb_addr),
        .wdata(bb_wdata), .hp_set(hp_valid),
        .sts(gpe_sts), .en(gpe_en), .rdata(bb_rdata)
    );

    slot_mask_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_masks (
        .clk(clk), .rst_n(rst_n), .we_ins(we_ins), .we_rem(we_rem),
        .wdata(wd_wdata), .hp_valid(hp_valid), .hp_slot(hp_slot),
        .hp_insert(hp_insert), .ins_mask(ins_mask), .rem_mask(rem_mask)
    );

    eject_encoder u_eject (
        .clk(clk), .rst_n(rst_n), .fire(we_ej), .wdata(wd_wdata),
        .eject_valid(eject_valid), .eject_slot(eject_slot)
    );

    // Word read multiplexer; eject and spare read as zero
    always_comb begin
        case (wd_word)
            W_INSERTED: wd_rdata = WORD_W'(ins_mask);
            W_REMOVED:  wd_rdata = WORD_W'(rem_mask);
            default:    wd_rdata = '0;
        endcase
    end

    // Interrupt pulse: one cycle per request when the event is enabled
    always_ff @(posedge clk) begin
        if (!rst_n) sci_irq <= 1'b0;
        else        sci_irq <= hp_valid && gpe_en[HP_BIT];
    end
endmodule

// File: rtl/gpe_hotplug_chk.sv
// Property checker for gpe_hotplug_regs, attached by bind below.
module gpe_hotplug_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int HP_BIT    = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hp_valid,
    input logic                 hp_insert,
    input logic                 sci_irq,
    input logic [15:0]          gpe_sts,
    input logic [15:0]          gpe_en,
    input logic [NUM_SLOTS-1:0] ins_mask,
    input logic [NUM_SLOTS-1:0] rem_mask,
    input logic                 bb_we,
    input logic [1:0]           bb_addr,
    input logic                 wd_we,
    input logic [1:0]           wd_word,
    input logic [31:0]          wd_wdata,
    input logic                 eject_valid
);
    // R5
    hp_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> gpe_sts[HP_BIT]);

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_irq |-> ($past(hp_valid) && $past(gpe_en[HP_BIT])));

    // R4
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> ($countones({ins_mask, rem_mask}) == 1));

    // R4
    insert_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && hp_insert) |=> (rem_mask == '0));

    // R3
    en_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_we && bb_addr == 2'd2) |=> (gpe_en[15:8] == $past(gpe_en[15:8])));

    // R8
    eject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> $past(wd_we && wd_word == 2'd2 && wd_wdata != '0));

    // R9
    eject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_we && wd_word == 2'd2 && wd_wdata == '0) |=> !eject_valid);
endmodule

bind gpe_hotplug_regs gpe_hotplug_chk #(.NUM_SLOTS(NUM_SLOTS), .HP_BIT(HP_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_insert(hp_insert),
    .sci_irq(sci_irq), .gpe_sts(gpe_sts), .gpe_en(gpe_en),
    .ins_mask(ins_mask), .rem_mask(rem_mask), .bb_we(bb_we),
    .bb_addr(bb_addr), .wd_we(wd_we), .wd_word(wd_word),
    .wd_wdata(wd_wdata), .eject_valid(eject_valid)
);

// File: tb/test_gpe_hotplug_regs.sv
`timescale 1ns/1ps
module test_gpe_hotplug_regs;
    localparam int TB_SLOTS = 8;
    localparam int TB_SW    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bb_we = 1'b0;
    logic [1:0]  bb_addr = '0;
    logic [7:0]  bb_wdata = '0;
    logic [7:0]  bb_rdata;
    logic        wd_we = 1'b0;
    logic [1:0]  wd_word = '0;
    logic [31:0] wd_wdata = '0;
    logic [31:0] wd_rdata;
    logic        hp_valid = 1'b0;
    logic [TB_SW-1:0] hp_slot = '0;
    logic        hp_insert = 1'b0;
    logic        sci_irq, eject_valid;
    logic [4:0]  eject_slot;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpe_hotplug_regs #(.NUM_SLOTS(TB_SLOTS), .HP_BIT(1)) i_gpe_hotplug_regs (
        .clk(clk), .rst_n(rst_n), .bb_we(bb_we), .bb_addr(bb_addr),
        .bb_wdata(bb_wdata), .bb_rdata(bb_rdata), .wd_we(wd_we),
        .wd_word(wd_word), .wd_wdata(wd_wdata), .wd_rdata(wd_rdata),
        .hp_valid(hp_valid), .hp_slot(hp_slot), .hp_insert(hp_insert),
        .sci_irq(sci_irq), .eject_valid(eject_valid), .eject_slot(eject_slot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd_b(input logic [1:0] a, output logic [7:0] v);
        bb_addr = a; #1; v = bb_rdata;
    endtask

    task automatic rd_w(input logic [1:0] a, output logic [31:0] v);
        wd_word = a; #1; v = wd_rdata;
    endtask

    task automatic wr_b(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); bb_we = 1'b1; bb_addr = a; bb_wdata = v;
        @(negedge clk); bb_we = 1'b0;
    endtask

    task automatic wr_w(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); wd_we = 1'b1; wd_word = a; wd_wdata = v;
        @(negedge clk); wd_we = 1'b0;
    endtask

    // Issue one request; report the interrupt in the following two cycles
    task automatic hotplug(input int slot, input logic ins, output logic irq1, output logic irq2);
        @(negedge clk); hp_valid = 1'b1; hp_slot = TB_SW'(slot); hp_insert = ins;
        @(negedge clk); hp_valid = 1'b0; irq1 = sci_irq;
        @(negedge clk); irq2 = sci_irq;
    endtask

    // Eject write; report strobe, index, and strobe one cycle later
    task automatic eject(input logic [31:0] v, output logic s1, output logic [4:0] ix, output logic s2);
        @(negedge clk); wd_we = 1'b1; wd_word = 2'd2; wd_wdata = v;
        @(negedge clk); wd_we = 1'b0; s1 = eject_valid; ix = eject_slot;
        @(negedge clk); s2 = eject_valid;
    endtask

    task automatic check_all_zero(input string req);
        logic [7:0] b; logic [31:0] w;
        for (int a = 0; a < 4; a++) begin rd_b(2'(a), b); chk(req, 32'(b), 0); end
        rd_w(2'd0, w); chk(req, w, 0);
        rd_w(2'd1, w); chk(req, w, 0);
        chk(req, 32'(sci_irq), 0);
        chk(req, 32'(eject_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [31:0] w;
        logic i1, i2, s1, s2;
        logic [4:0] ix;
        logic [15:0] en_exp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check_all_zero("R10 reset");

        // R3 / R1: enable lane sweep, both lanes read back
        en_exp = '0;
        for (int ln = 0; ln < 2; ln++) begin
            for (int v = 0; v < 256; v++) begin
                wr_b(2'(2 + ln), 8'(v));
                en_exp[ln*8 +: 8] = 8'(v);
                rd_b(2'd2, b); chk("R3 enable lo", 32'(b), 32'(en_exp[7:0]));
                rd_b(2'd3, b); chk("R3 enable hi", 32'(b), 32'(en_exp[15:8]));
            end
        end
        wr_b(2'd2, 8'h00); wr_b(2'd3, 8'h00);

        // R2 / R5 / R1: status clear sweep on lane 0, interrupt disabled
        for (int v = 0; v < 256; v++) begin
            hotplug(0, 1'b1, i1, i2);
            chk("R6 disabled no irq", 32'(i1), 0);
            rd_b(2'd0, b); chk("R5 status set", 32'(b), 32'h2);
            wr_b(2'd0, 8'(v));
            rd_b(2'd0, b); chk("R2 status lo clear", 32'(b), 32'(8'h2 & ~8'(v)));
            rd_b(2'd1, b); chk("R1 status hi", 32'(b), 0);
        end
        // R2: writes to the high lane leave the low lane alone
        hotplug(1, 1'b1, i1, i2);
        for (int v = 0; v < 256; v++) begin
            wr_b(2'd1, 8'(v));
            rd_b(2'd0, b); chk("R2 other lane kept", 32'(b), 32'h2);
        end
        wr_b(2'd0, 8'hFF);

        // R4 / R6: every slot, both directions, interrupt enabled
        wr_b(2'd2, 8'h02);
        for (int s = 0; s < TB_SLOTS; s++) begin
            for (int d = 0; d < 2; d++) begin
                hotplug(s, d[0], i1, i2);
                chk("R6 pulse high", 32'(i1), 1);
                chk("R6 pulse low after", 32'(i2), 0);
                rd_w(2'd0, w); chk("R4 inserted mask", w, d[0] ? 32'(1) << s : 0);
                rd_w(2'd1, w); chk("R4 removed mask", w, d[0] ? 0 : 32'(1) << s);
            end
        end

        // R7: software mask access and bits above the slot count
        wr_w(2'd0, 32'hFFFF_FFA5);
        rd_w(2'd0, w); chk("R7 inserted rw", w, 32'hA5);
        wr_w(2'd1, 32'h1234_5678);
        rd_w(2'd1, w); chk("R7 removed rw", w, 32'h78);
        // R4: a request wipes software-written masks
        hotplug(3, 1'b0, i1, i2);
        rd_w(2'd0, w); chk("R4 wipe inserted", w, 0);
        rd_w(2'd1, w); chk("R4 wipe removed", w, 32'h8);

        // R7: request overrides same-cycle mask write
        @(negedge clk); wd_we = 1'b1; wd_word = 2'd0; wd_wdata = 32'hFF;
        hp_valid = 1'b1; hp_slot = 3'd6; hp_insert = 1'b1;
        @(negedge clk); wd_we = 1'b0; hp_valid = 1'b0;
        rd_w(2'd0, w); chk("R7 hotplug wins mask", w, 32'h40);

        // R5: request overrides same-cycle status clear
        wr_b(2'd0, 8'hFF);
        @(negedge clk); bb_we = 1'b1; bb_addr = 2'd0; bb_wdata = 8'h02;
        hp_valid = 1'b1; hp_slot = 3'd2; hp_insert = 1'b0;
        @(negedge clk); bb_we = 1'b0; hp_valid = 1'b0;
        rd_b(2'd0, b); chk("R5 set wins clear", 32'(b), 32'h2);

        // R6: enable bit 1 clear, other enable bits set: no pulse
        wr_b(2'd2, 8'hFD); wr_b(2'd3, 8'hFF);
        hotplug(4, 1'b1, i1, i2);
        chk("R6 no pulse", 32'(i1), 0);
        chk("R6 no pulse later", 32'(i2), 0);

        // R8: walking bit and walking bit with top bit added
        for (int k = 0; k < 32; k++) begin
            eject(32'(1) << k, s1, ix, s2);
            chk("R8 strobe", 32'(s1), 1);
            chk("R8 slot", 32'(ix), k);
            chk("R8 single cycle", 32'(s2), 0);
            eject((32'(1) << k) | 32'h8000_0000, s1, ix, s2);
            chk("R8 lowest bit", 32'(ix), k);
        end
        eject(32'hFFFF_FFFF, s1, ix, s2);
        chk("R8 all ones", 32'(ix), 0);
        rd_w(2'd2, w); chk("R8 eject reads zero", w, 0);
        rd_w(2'd3, w); chk("R8 spare reads zero", w, 0);

        // R9: zero write gives no strobe
        eject(32'h0, s1, ix, s2);
        chk("R9 no strobe", 32'(s1), 0);
        chk("R9 no strobe later", 32'(s2), 0);

        // R10: mid-run reset clears everything
        wr_w(2'd0, 32'h3C);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_all_zero("R10 mid-run reset");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule